// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of general-purpose input pins arranged in three groups. Group 0 holds pins 0 to 7, group 1 holds pins 8 to 14, and group 2 holds pins 16 to 23. Position 15 has no pin. Each pin passes through a two-flop synchronizer. A change in either direction on a pin whose mask bit is set raises the sticky flag of its group.

A flag is cleared in one of two ways. Software can write a one to its bit in the flag register, or the processor can pulse the acknowledge line of that group when it takes the group's vector. A group drives its interrupt request while three things hold: its flag is set, its enable bit is set, and the global interrupt-enable input is high. The block also gives one combined request line and the number of the lowest pending group.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and no request output is active.
- R2: The register map is as follows. Address 0 holds the group enables in bits 2:0. Address 1 holds the group flags in bits 2:0. Addresses 2, 3 and 4 hold the pin masks of groups 0, 1 and 2, where mask bit k belongs to pin 8*g+k. Bits 7:3 of addresses 0 and 1 always read zero and ignore writes. Addresses 5 to 7 read zero.
- R3: Group 1 has no pin 15. Bit 7 of its mask reads zero and cannot be set, and toggling input 15 never sets any flag.
- R4: A rising or falling change on a pin whose mask bit is set sets the flag of that pin's group. The flag becomes visible on the third rising clock edge after the input changes.
- R5: A change on a pin whose mask bit is clear does not affect any flag.
- R6: Writing a one to bit g of the flag register clears flag g. Writing a zero leaves that flag unchanged.
- R7: A one-cycle pulse on acknowledge bit g clears flag g.
- R8: When a detected change and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R9: Request g is high exactly when flag g, enable bit g and the global enable are all one. Flags still set while requests are gated off.
- R10: The combined request is the OR of the group requests. The vector-id output gives the lowest-numbered active group, and reads 0 when no group is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 24 | Watched input pins, asynchronous to clk |
| gie | input | 1 | Global interrupt enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| grp_ack | input | 3 | Per-group vector-taken pulse |
| grp_irq | output | 3 | Per-group interrupt requests |
| irq_any | output | 1 | OR of all group requests |
| irq_vec | output | 2 | Lowest-numbered active group |

## Verification
The properties assume that acknowledge is pulsed only for one cycle at a time. They also assume that pin inputs are held stable for at least one clock, so that each level reaches the synchronizer's last stage and produces a change event. The bench follows these rules. It drives every pin, the acknowledge lines and the register strobe only on falling edges, holds each pin level for several cycles, and gives each acknowledge a single cycle. The set-versus-clear collision is produced by timing the acknowledge to the exact cycle in which a synchronized change reaches the detector.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
   localparam int unsigned ADDR_EN        = 0;
   localparam int unsigned ADDR_FLAG      = 1;
   localparam int unsigned ADDR_MASK_BASE = 2;

   function automatic int unsigned vec_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pcic_sync.sv
module pcic_sync #(
   parameter int unsigned W      = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] chg
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcic_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], d};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign chg = stg_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pcic_regs.sv
module pcic_regs #(
   parameter int unsigned          NUM_GRP     = 3,
   parameter int unsigned          GRP_W       = 8,
   parameter int unsigned          AW          = 3,
   parameter int unsigned          DW          = 8,
   parameter logic [NUM_GRP*GRP_W-1:0] PIN_PRESENT = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [AW-1:0]            reg_addr,
   input  logic [DW-1:0]            reg_wdata,
   output logic [DW-1:0]            reg_rdata,
   input  logic [NUM_GRP-1:0]       flag,
   output logic [NUM_GRP-1:0]       en,
   output logic [NUM_GRP*GRP_W-1:0] mask,
   output logic [NUM_GRP-1:0]       w1c
);
   import pcic_pkg::*;

   localparam int unsigned NREG = ADDR_MASK_BASE + NUM_GRP;

   if (DW < GRP_W || DW < NUM_GRP) begin : g_bad_dw
      $error("pcic_regs: DW too narrow");
   end
   if (NREG > (1 << AW)) begin : g_bad_aw
      $error("pcic_regs: AW too narrow for register map");
   end

   logic [NUM_GRP-1:0]       en_q;
   logic [NUM_GRP*GRP_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == AW'(ADDR_EN))
            en_q <= reg_wdata[NUM_GRP-1:0];
         for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr == AW'(ADDR_MASK_BASE + g))
               mask_q[g*GRP_W +: GRP_W] <= reg_wdata[GRP_W-1:0] & PIN_PRESENT[g*GRP_W +: GRP_W];
         end
      end
   end

   assign w1c  = (reg_we && reg_addr == AW'(ADDR_FLAG)) ? reg_wdata[NUM_GRP-1:0] : '0;
   assign en   = en_q;
   assign mask = mask_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(ADDR_EN))
         reg_rdata[NUM_GRP-1:0] = en_q;
      if (reg_addr == AW'(ADDR_FLAG))
         reg_rdata[NUM_GRP-1:0] = flag;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (reg_addr == AW'(ADDR_MASK_BASE + g))
            reg_rdata[GRP_W-1:0] = mask_q[g*GRP_W +: GRP_W];
      end
   end
endmodule

// File: rtl/pcic_flag_grp.sv
module pcic_flag_grp #(
   parameter int unsigned GRP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_W-1:0] chg,
   input  logic [GRP_W-1:0] mask,
   input  logic             w1c,
   input  logic             ack,
   input  logic             en,
   input  logic             gie,
   output logic             hit,
   output logic             flag,
   output logic             req
);
   logic flag_q;

   assign hit = |(chg & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (hit)
         flag_q <= 1'b1;
      else if (w1c || ack)
         flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign req  = flag_q & en & gie;
endmodule

// File: rtl/pcic_prio.sv
module pcic_prio #(
   parameter int unsigned N  = 3,
   parameter int unsigned VW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [VW-1:0] vec
);
   always_comb begin
      vec = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) vec = VW'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl #(
   parameter int unsigned NUM_GRP     = 3,
   parameter int unsigned GRP_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AW          = 3,
   parameter int unsigned DW          = 8,
   parameter logic [NUM_GRP*GRP_W-1:0] PIN_PRESENT = 24'hFF_7FFF,
   localparam int unsigned PINS  = NUM_GRP * GRP_W,
   localparam int unsigned VEC_W = pcic_pkg::vec_width(NUM_GRP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PINS-1:0]    pin_in,
   input  logic               gie,
   input  logic               reg_we,
   input  logic [AW-1:0]      reg_addr,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   input  logic [NUM_GRP-1:0] grp_ack,
   output logic [NUM_GRP-1:0] grp_irq,
   output logic               irq_any,
   output logic [VEC_W-1:0]   irq_vec
);
   if (NUM_GRP < 1 || NUM_GRP > DW) begin : g_bad_grp
      $error("pinchg_irq_ctrl: NUM_GRP out of range");
   end

   logic [PINS-1:0]    chg_vec;
   logic [PINS-1:0]    mask_vec;
   logic [NUM_GRP-1:0] en_vec;
   logic [NUM_GRP-1:0] flag_vec;
   logic [NUM_GRP-1:0] hit_vec;
   logic [NUM_GRP-1:0] w1c_vec;

   pcic_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .chg   (chg_vec)
   );

   pcic_regs #(
      .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .AW(AW), .DW(DW), .PIN_PRESENT(PIN_PRESENT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flag      (flag_vec),
      .en        (en_vec),
      .mask      (mask_vec),
      .w1c       (w1c_vec)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      pcic_flag_grp #(.GRP_W(GRP_W)) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .chg   (chg_vec[g*GRP_W +: GRP_W]),
         .mask  (mask_vec[g*GRP_W +: GRP_W]),
         .w1c   (w1c_vec[g]),
         .ack   (grp_ack[g]),
         .en    (en_vec[g]),
         .gie   (gie),
         .hit   (hit_vec[g]),
         .flag  (flag_vec[g]),
         .req   (grp_irq[g])
      );
   end

   pcic_prio #(.N(NUM_GRP), .VW(VEC_W)) u_prio (
      .req (grp_irq),
      .any (irq_any),
      .vec (irq_vec)
   );
endmodule

// File: rtl/pcic_chk.sv
module pcic_chk #(
   parameter int unsigned NUM_GRP = 3,
   parameter int unsigned AW      = 3,
   parameter int unsigned DW      = 8,
   parameter int unsigned VW      = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               gie,
   input logic [AW-1:0]      reg_addr,
   input logic [DW-1:0]      reg_rdata,
   input logic [NUM_GRP-1:0] grp_ack,
   input logic [NUM_GRP-1:0] grp_irq,
   input logic               irq_any,
   input logic [VW-1:0]      irq_vec,
   input logic [NUM_GRP-1:0] flag,
   input logic [NUM_GRP-1:0] hit
);
   // R2: upper bits of the enable and flag registers read zero
   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr < AW'(2)) |-> (reg_rdata[DW-1:NUM_GRP] == '0));

   // R10: combined line agrees with the group requests
   a_r10_any_match: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == (grp_irq != '0));

   // R10: the vector id points at an active group
   a_r10_vec_active: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any |-> grp_irq[irq_vec]);

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
      // R9: no request without the global enable and the flag
      a_r9_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
         grp_irq[g] |-> (gie && flag[g]));

      // R4 / R8: a detected change leaves the flag set, whatever clears it
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         hit[g] |=> flag[g]);

      // R7: acknowledge with no competing change clears the flag
      a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_ack[g] && !hit[g]) |=> !flag[g]);

      // R10: the vector id never exceeds an active group number
      a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
         grp_irq[g] |-> (int'(irq_vec) <= g));
   end
endmodule

bind pinchg_irq_ctrl pcic_chk #(
   .NUM_GRP(NUM_GRP), .AW(AW), .DW(DW), .VW(VEC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gie       (gie),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .grp_ack   (grp_ack),
   .grp_irq   (grp_irq),
   .irq_any   (irq_any),
   .irq_vec   (irq_vec),
   .flag      (flag_vec),
   .hit       (hit_vec)
);

// File: tb/pinchg_irq_ctrl_tb.sv
module pinchg_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] pins = '0;
   logic        gie = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [2:0]  ack = '0;
   logic [2:0]  irq;
   logic        any;
   logic [1:0]  vec;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pinchg_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pins), .gie(gie),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .grp_ack(ack), .grp_irq(irq), .irq_any(any), .irq_vec(vec)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic toggle(input int p);
      @(negedge clk);
      pins[p] = ~pins[p];
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [1:0] lowest(input logic [2:0] r);
      for (int i = 2; i >= 0; i--) if (r[i]) lowest = 2'(i);
      if (r == '0) lowest = 2'd0;
   endfunction

   initial begin
      #500000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         reg_rd(3'(a), d);
         check("R1 reset reg", d, 0);
      end
      check("R1 reset irq", {any, irq}, 0);

      // R2 / R3: map, reserved bits, missing pin 15
      reg_wr(0, 8'hFF); reg_rd(0, d); check("R2 enable rsvd", d, 8'h07);
      reg_wr(1, 8'hFF); reg_rd(1, d); check("R2 flag rsvd", d, 8'h00);
      reg_wr(2, 8'hFF); reg_rd(2, d); check("R2 mask0", d, 8'hFF);
      reg_wr(3, 8'hFF); reg_rd(3, d); check("R3 mask1 bit7", d, 8'h7F);
      reg_wr(4, 8'hFF); reg_rd(4, d); check("R2 mask2", d, 8'hFF);
      for (int a = 5; a < 8; a++) begin
         reg_wr(3'(a), 8'hA5); reg_rd(3'(a), d); check("R2 unused addr", d, 0);
      end

      // R4 / R3 / R9: every pin, both edges, gie low
      for (int p = 0; p < 24; p++) begin
         for (int e = 0; e < 2; e++) begin
            reg_wr(1, 8'h07);
            toggle(p);
            reg_rd(1, d);
            check(p == 15 ? "R3 pin15" : "R4 edge sweep", d, (p == 15) ? 0 : (1 << (p / 8)));
            check("R9 gie gate", irq, 0);
         end
      end

      // R5: masked-off pins
      for (int g = 0; g < 3; g++) begin
         reg_wr(1, 8'h07);
         reg_wr(3'(2 + g), 8'h01);
         toggle(g * 8 + 1);
         reg_rd(1, d); check("R5 masked pin", d, 0);
         toggle(g * 8);
         reg_rd(1, d); check("R5 unmasked pin", d, 1 << g);
         reg_wr(3'(2 + g), 8'hFF);
      end

      // R6: write-one-to-clear
      reg_wr(1, 8'h07);
      toggle(0); toggle(8); toggle(16);
      reg_rd(1, d); check("R6 all set", d, 8'h07);
      reg_wr(1, 8'h00); reg_rd(1, d); check("R6 zero write", d, 8'h07);
      reg_wr(1, 8'h02); reg_rd(1, d); check("R6 clear one", d, 8'h05);
      reg_wr(1, 8'h05); reg_rd(1, d); check("R6 clear rest", d, 8'h00);

      // R7: acknowledge
      toggle(0); toggle(8); toggle(16);
      @(negedge clk); ack = 3'b010; @(negedge clk); ack = '0;
      reg_rd(1, d); check("R7 ack one", d, 8'h05);
      @(negedge clk); ack = 3'b101; @(negedge clk); ack = '0;
      reg_rd(1, d); check("R7 ack rest", d, 8'h00);

      // R8: change and acknowledge in the same cycle
      toggle(0);
      @(negedge clk); pins[0] = ~pins[0];
      @(negedge clk);
      @(negedge clk); ack = 3'b001;
      @(negedge clk); ack = '0;
      reg_rd(1, d); check("R8 set wins ack", d, 8'h01);
      @(negedge clk); pins[0] = ~pins[0];
      @(negedge clk);
      @(negedge clk); we = 1'b1; addr = 3'd1; wdata = 8'h01;
      @(negedge clk); we = 1'b0;
      reg_rd(1, d); check("R8 set wins w1c", d, 8'h01);

      // R9 / R10: flags x enables x global enable
      for (int f = 0; f < 8; f++) begin
         reg_wr(1, 8'h07);
         for (int g = 0; g < 3; g++) if (f[g]) toggle(g * 8);
         for (int en = 0; en < 8; en++) begin
            for (int gi = 0; gi < 2; gi++) begin
               logic [2:0] exp_irq;
               gie = gi[0];
               reg_wr(0, 8'(en));
               #1;
               exp_irq = 3'(f) & 3'(en) & {3{gi[0]}};
               check("R9 request", irq, exp_irq);
               check("R10 any/vec", {any, vec}, {(exp_irq != 0), lowest(exp_irq)});
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule